// File: doc/BRIEF.md
# Three-Rail Power Sequencing Controller

This controller drives three rail-enable flags from one synchronized enable input. When enable rises, the flags are released one after another in a fixed order: rail 0, then rail 1, then rail 2. A programmable wait comes before each release. When enable falls, the flags are pulled low again. A selectable permutation sets the order, and a second set of programmable waits applies. Each flag is meant to drive the enable input of one regulator, so supplies start and stop in a controlled way.

Every wait is a 4-bit code multiplied by a step of 2, 4, 6 or 8 milliseconds. One range select chooses the step for all six waits. A restartable prescaler turns the clock into millisecond ticks. The controller handles three kinds of enable drop-out:

- **Before any rail is up:** a short enable pulse is rejected.
- **Part-way through power-up:** the power-up is completed, the controller holds for a settle time, and then it powers down.
- **With all rails up:** a normal power-down starts.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, `rail_o` is 3'b000 and `phase_o` is 0. Both stay there for as long as `en_i` is low.
- R2: Let edge k be the first rising clock edge that samples `en_i` high while `phase_o` is 0. Rail 0 goes high at edge k+1+E+N1·T. Each later rail goes high Nj·T+1 edges after the one before it. T is CYC_PER_TICK, E is EXTRA_CYC, and Nj is wait j in ticks. The release order is always rail 0, then rail 1, then rail 2, and at most one rail changes per cycle.
- R3: Wait j in ticks is its code times the step in milliseconds. Range select values 0, 1, 2 and 3 give steps of 2, 4, 6 and 8. Code 0 gives zero ticks, so that stage takes only its fixed cycles. The power-up codes sit in `up_code_i`, with wait j+1 in bits [4j+3:4j]. The power-down codes sit the same way in `dn_code_i`.
- R4: When `phase_o` is 2 and an edge samples `en_i` low, the first rail drops E+N4·T+1 edges later. The second rail drops N5·T+1 edges after the first, and the third drops N6·T+1 edges after the second. No rail rises during power-down.
- R5: `dn_order_i` sets the drop order. The six values list the order by rail number:

  | `dn_order_i` | Drop order |
  |---|---|
  | 0 | 2, 1, 0 |
  | 1 | 2, 0, 1 |
  | 2 | 1, 2, 0 |
  | 3 | 1, 0, 2 |
  | 4 | 0, 2, 1 |
  | 5 | 0, 1, 2 |

  Values 6 and 7 behave as 0. The order is sampled when the power-down begins.
- R6: If an edge samples `en_i` low while power-up is running and no rail is up yet, the controller returns to `phase_o` 0 at that edge. Every rail stays low.
- R7: If `en_i` is first sampled low after rail 0 is up but before rail 2 is up, three things happen:
  - The wait in progress restarts at that edge, and the power-up then completes.
  - Any further change on `en_i` is ignored until the controller is idle again.
  - The controller waits SETTLE_TICKS·T+1 edges after the last release. It then runs the power-down of R4, with its first wait counted from the end of the settle.
- R8: Raising `en_i` during a power-down has no effect on the drops. After the last drop, `phase_o` is 0 for one cycle. If `en_i` is still high, a new power-up then begins with the timing of R2.
- R9: `phase_o` shows the sequencing phase:
  - 0: off.
  - 1: power-up in progress.
  - 2: all rails on.
  - 3: power-down in progress, including the settle wait of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| en_i | input | 1 | Synchronized sequencing enable |
| up_code_i | input | 12 | Three 4-bit power-up wait codes |
| dn_code_i | input | 12 | Three 4-bit power-down wait codes |
| range_sel_i | input | 2 | Step range select shared by all waits |
| dn_order_i | input | 3 | Power-down permutation select |
| rail_o | output | 3 | Rail release flags, bit r high lets rail r run |
| phase_o | output | 2 | Sequencing phase indication |

## Verification
An internal fault shows at the ports in a few predictable ways:
- **Timer or prescaler fault:** a release or drop edge moves off its predicted clock edge. The bench sees this at the very next flag change, because it measures the edge count between consecutive flag changes rather than only the final state.
- **Wrong state or abort flag:** a rail rises out of order, a rail rises during power-down, or a short enable pulse is not cancelled. These show within one cycle as a wrong flag vector or a wrong `phase_o` value.
- **Wrong permutation decode:** a different rail drops first. This shows on the first drop of the power-down.

// File: rtl/rs_pkg.sv
package rs_pkg;

   localparam int unsigned CODE_W    = 4;
   localparam int unsigned RANGE_W   = 2;
   localparam int unsigned ORDER_W   = 3;
   localparam int unsigned N_RAILS   = 3;
   localparam int unsigned MAX_STAGE = 120;   // largest code times largest step

   typedef enum logic [3:0] {
      S_IDLE, S_UP0, S_UP1, S_UP2, S_ON, S_HOLD, S_DN0, S_DN1, S_DN2
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_OFF = 2'd0, PH_UP = 2'd1, PH_ON = 2'd2, PH_DN = 2'd3
   } phase_e;

   // wait length in ticks for one code under the shared range select
   function automatic logic [7:0] stage_ticks(input logic [CODE_W-1:0] code,
                                              input logic [RANGE_W-1:0] sel);
      logic [3:0] step;
      step = {1'b0, sel, 1'b0} + 4'd2;
      return 8'(code * step);
   endfunction

   // rail dropped at position pos of the selected power-down permutation
   function automatic logic [1:0] drop_rail(input logic [ORDER_W-1:0] ord,
                                            input int unsigned pos);
      logic [5:0] seq;   // {third, second, first}
      case (ord)
         3'd1:    seq = {2'd1, 2'd0, 2'd2};
         3'd2:    seq = {2'd0, 2'd2, 2'd1};
         3'd3:    seq = {2'd2, 2'd0, 2'd1};
         3'd4:    seq = {2'd1, 2'd2, 2'd0};
         3'd5:    seq = {2'd2, 2'd1, 2'd0};
         default: seq = {2'd0, 2'd1, 2'd2};
      endcase
      return seq[pos*2 +: 2];
   endfunction

endpackage

// File: rtl/rs_tick_div.sv
module rs_tick_div #(
   parameter int CYC_PER_TICK = 125000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic run_i,
   output logic tick_o
);

   if (CYC_PER_TICK < 1) begin : g_bad_div
      $error("CYC_PER_TICK must be at least 1");
   end

   generate
      if (CYC_PER_TICK == 1) begin : g_pass
         logic unused_clear;
         assign unused_clear = clear_i ^ clk_i ^ rst_ni;
         assign tick_o = run_i;
      end else begin : g_count
         localparam int DIV_W = $clog2(CYC_PER_TICK);
         localparam logic [DIV_W-1:0] LAST = DIV_W'(CYC_PER_TICK - 1);
         logic [DIV_W-1:0] div_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)            div_q <= '0;
            else if (clear_i)       div_q <= '0;
            else if (run_i) begin
               if (div_q == LAST)   div_q <= '0;
               else                 div_q <= div_q + 1'b1;
            end
         end

         assign tick_o = run_i && (div_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/rs_stage_timer.sv
module rs_stage_timer #(
   parameter int CYC_PER_TICK = 125000,
   parameter int EXTRA_CYC    = 50000,
   parameter int TICK_W       = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              extra_i,
   input  logic [TICK_W-1:0] target_i,
   output logic              expired_o
);

   if (EXTRA_CYC < 0) begin : g_bad_extra
      $error("EXTRA_CYC must not be negative");
   end
   if (TICK_W < 1) begin : g_bad_w
      $error("TICK_W must be at least 1");
   end

   logic              running_q;
   logic              pre_done;
   logic              tick;
   logic              count_en;
   logic [TICK_W-1:0] tick_cnt_q;
   logic [TICK_W-1:0] target_q;

   // fixed pre-delay ahead of the tick count, present only when configured
   generate
      if (EXTRA_CYC == 0) begin : g_no_pre
         logic unused_extra;
         assign unused_extra = extra_i;
         assign pre_done = 1'b1;
      end else begin : g_pre
         localparam int PRE_W = $clog2(EXTRA_CYC + 1);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)            pre_q <= '0;
            else if (start_i)       pre_q <= extra_i ? PRE_W'(EXTRA_CYC) : '0;
            else if (pre_q != '0)   pre_q <= pre_q - 1'b1;
         end

         assign pre_done = (pre_q == '0);
      end
   endgenerate

   assign count_en = running_q && pre_done && (tick_cnt_q != target_q);

   rs_tick_div #(.CYC_PER_TICK(CYC_PER_TICK)) div_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (start_i),
      .run_i   (count_en),
      .tick_o  (tick)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         running_q  <= 1'b0;
         tick_cnt_q <= '0;
         target_q   <= '0;
      end else if (start_i) begin
         running_q  <= 1'b1;
         tick_cnt_q <= '0;
         target_q   <= target_i;
      end else if (tick) begin
         tick_cnt_q <= tick_cnt_q + 1'b1;
      end
   end

   assign expired_o = running_q && pre_done && (tick_cnt_q == target_q);

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
   import rs_pkg::*;
#(
   parameter int CYC_PER_TICK = 125000,
   parameter int EXTRA_CYC    = 50000,
   parameter int SETTLE_TICKS = 120
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        en_i,
   input  logic [11:0] up_code_i,
   input  logic [11:0] dn_code_i,
   input  logic [1:0]  range_sel_i,
   input  logic [2:0]  dn_order_i,
   output logic [2:0]  rail_o,
   output logic [1:0]  phase_o
);

   localparam int MAX_TICKS = (SETTLE_TICKS > int'(MAX_STAGE)) ? SETTLE_TICKS : int'(MAX_STAGE);
   localparam int TICK_W    = $clog2(MAX_TICKS + 1);

   if (SETTLE_TICKS < 0) begin : g_bad_settle
      $error("SETTLE_TICKS must not be negative");
   end
   if (N_RAILS * CODE_W != 12) begin : g_bad_codes
      $error("code buses must hold one code per rail");
   end

   seq_state_e           st_q, st_d;
   logic                 abort_q, abort_d;
   logic [ORDER_W-1:0]   ord_q, ord_d;
   logic                 start, extra, expired;
   logic [TICK_W-1:0]    tgt;
   logic [N_RAILS-1:0]   set_v, clr_v, rail_q;
   logic [TICK_W-1:0]    up_ticks [N_RAILS];
   logic [TICK_W-1:0]    dn_ticks [N_RAILS];
   logic [1:0]           drop_idx [N_RAILS];

   // per-stage wait lengths and the latched drop permutation
   for (genvar k = 0; k < N_RAILS; k++) begin : g_stage
      assign up_ticks[k] = TICK_W'(stage_ticks(up_code_i[k*CODE_W +: CODE_W], range_sel_i));
      assign dn_ticks[k] = TICK_W'(stage_ticks(dn_code_i[k*CODE_W +: CODE_W], range_sel_i));
      assign drop_idx[k] = drop_rail(ord_q, k);
   end

   rs_stage_timer #(
      .CYC_PER_TICK (CYC_PER_TICK),
      .EXTRA_CYC    (EXTRA_CYC),
      .TICK_W       (TICK_W)
   ) timer_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .extra_i   (extra),
      .target_i  (tgt),
      .expired_o (expired)
   );

   always_comb begin
      st_d    = st_q;
      abort_d = abort_q;
      ord_d   = ord_q;
      start   = 1'b0;
      extra   = 1'b0;
      tgt     = '0;
      set_v   = '0;
      clr_v   = '0;
      case (st_q)
         S_IDLE: if (en_i) begin
            st_d = S_UP0; start = 1'b1; extra = 1'b1; tgt = up_ticks[0];
         end
         S_UP0: begin
            if (!en_i) begin
               st_d = S_IDLE;
            end else if (expired) begin
               set_v[0] = 1'b1; st_d = S_UP1; start = 1'b1; tgt = up_ticks[1];
            end
         end
         S_UP1: begin
            if (!en_i && !abort_q) begin
               abort_d = 1'b1; start = 1'b1; tgt = up_ticks[1];
            end else if (expired) begin
               set_v[1] = 1'b1; st_d = S_UP2; start = 1'b1; tgt = up_ticks[2];
            end
         end
         S_UP2: begin
            if (!en_i && !abort_q) begin
               abort_d = 1'b1; start = 1'b1; tgt = up_ticks[2];
            end else if (expired) begin
               set_v[2] = 1'b1;
               if (abort_q) begin
                  st_d = S_HOLD; start = 1'b1; tgt = TICK_W'(SETTLE_TICKS);
               end else begin
                  st_d = S_ON;
               end
            end
         end
         S_ON: if (!en_i) begin
            st_d = S_DN0; start = 1'b1; extra = 1'b1; tgt = dn_ticks[0]; ord_d = dn_order_i;
         end
         S_HOLD: if (expired) begin
            abort_d = 1'b0; st_d = S_DN0; start = 1'b1; extra = 1'b1;
            tgt = dn_ticks[0]; ord_d = dn_order_i;
         end
         S_DN0: if (expired) begin
            clr_v[drop_idx[0]] = 1'b1; st_d = S_DN1; start = 1'b1; tgt = dn_ticks[1];
         end
         S_DN1: if (expired) begin
            clr_v[drop_idx[1]] = 1'b1; st_d = S_DN2; start = 1'b1; tgt = dn_ticks[2];
         end
         S_DN2: if (expired) begin
            clr_v[drop_idx[2]] = 1'b1; st_d = S_IDLE; abort_d = 1'b0;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= S_IDLE;
         abort_q <= 1'b0;
         ord_q   <= '0;
      end else begin
         st_q    <= st_d;
         abort_q <= abort_d;
         ord_q   <= ord_d;
      end
   end

   // one flag register per rail
   for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        rail_q[r] <= 1'b0;
         else if (set_v[r])  rail_q[r] <= 1'b1;
         else if (clr_v[r])  rail_q[r] <= 1'b0;
      end
   end

   always_comb begin
      case (st_q)
         S_UP0, S_UP1, S_UP2:         phase_o = PH_UP;
         S_ON:                        phase_o = PH_ON;
         S_HOLD, S_DN0, S_DN1, S_DN2: phase_o = PH_DN;
         default:                     phase_o = PH_OFF;
      endcase
   end

   assign rail_o = rail_q;

endmodule

// File: rtl/rs_seq_checker.sv
module rs_seq_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       en_i,
   input logic [2:0] rail_o,
   input logic [1:0] phase_o
);

   assert_off_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == 2'd0) |-> (rail_o == 3'b000));

   assert_one_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(rail_o ^ $past(rail_o)) <= 1);

   assert_order_mid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rail_o[1]) |-> rail_o[0]);

   assert_order_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rail_o[2]) |-> (rail_o[1] && rail_o[0]));

   assert_no_rise_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == 2'd3 && $past(phase_o) == 2'd3) |-> ((rail_o & ~$past(rail_o)) == 3'b000));

   assert_on_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == 2'd2 && !en_i) |=> (phase_o == 2'd3));

   assert_cancel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == 2'd1 && rail_o == 3'b000 && !en_i) |=> (phase_o == 2'd0 && rail_o == 3'b000));

   assert_on_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_o == 2'd2) |-> (rail_o == 3'b111));

endmodule

bind rail_seq_ctrl rs_seq_checker chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .en_i    (en_i),
   .rail_o  (rail_o),
   .phase_o (phase_o)
);

// File: tb/rail_seq_ctrl_tb_top.sv
module rail_seq_ctrl_tb_top;

   localparam int CPT = 3;
   localparam int EXT = 2;
   localparam int STL = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [11:0] up_c = '0;
   logic [11:0] dn_c = '0;
   logic [1:0]  sel = '0;
   logic [2:0]  ord = '0;
   logic [2:0]  rail;
   logic [1:0]  phase;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   rail_seq_ctrl #(
      .CYC_PER_TICK (CPT),
      .EXTRA_CYC    (EXT),
      .SETTLE_TICKS (STL)
   ) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .en_i        (en),
      .up_code_i   (up_c),
      .dn_code_i   (dn_c),
      .range_sel_i (sel),
      .dn_order_i  (ord),
      .rail_o      (rail),
      .phase_o     (phase)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ticks_cyc(logic [11:0] codes, int k, int s);
      return int'(codes[k*4 +: 4]) * 2 * (s + 1) * CPT;
   endfunction

   function automatic int drop_at(int o, int p);
      int t[6][3] = '{'{2,1,0}, '{2,0,1}, '{1,2,0}, '{1,0,2}, '{0,2,1}, '{0,1,2}};
      return (o > 5) ? t[0][p] : t[o][p];
   endfunction

   task automatic set_en(logic v);
      @(negedge clk);
      en = v;
   endtask

   task automatic wait_rail(output int n);
      logic [2:0] prev;
      prev = rail;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (rail == prev && n < 4000);
   endtask

   task automatic configure(int s, logic [11:0] u, logic [11:0] d, int o);
      @(negedge clk);
      sel = 2'(s); up_c = u; dn_c = d; ord = 3'(o);
   endtask

   // power-up from idle, R2/R3/R9
   task automatic run_up(string tag);
      int n;
      set_en(1'b1);
      wait_rail(n);
      check({tag, " R2 rail0 delay"}, n, 2 + EXT + ticks_cyc(up_c, 0, sel));
      check({tag, " R2 rail0 value"}, rail, 3'b001);
      check({tag, " R9 phase up"}, phase, 1);
      wait_rail(n);
      check({tag, " R3 rail1 delay"}, n, 1 + ticks_cyc(up_c, 1, sel));
      check({tag, " R2 rail1 value"}, rail, 3'b011);
      wait_rail(n);
      check({tag, " R3 rail2 delay"}, n, 1 + ticks_cyc(up_c, 2, sel));
      check({tag, " R2 rail2 value"}, rail, 3'b111);
   endtask

   // three drops, first one expected first_n edges after the reference
   task automatic run_down(string tag, int first_n);
      int n;
      logic [2:0] exp_v;
      exp_v = 3'b111;
      for (int p = 0; p < 3; p++) begin
         wait_rail(n);
         exp_v[drop_at(ord, p)] = 1'b0;
         check({tag, " R4 drop delay"}, n, (p == 0) ? first_n : 1 + ticks_cyc(dn_c, p, sel));
         check({tag, " R5 drop order"}, rail, exp_v);
         if (p == 0) check({tag, " R9 phase down"}, phase, 3);
      end
      check({tag, " R9 phase off"}, phase, 0);
   endtask

   task automatic t_reset();
      check("R1 reset rails", rail, 0);
      check("R1 reset phase", phase, 0);
      repeat (20) @(negedge clk);
      check("R1 rails held low", rail, 0);
   endtask

   task automatic t_full(string tag, int s, logic [11:0] u, logic [11:0] d, int o);
      configure(s, u, d, o);
      run_up(tag);
      @(negedge clk);
      check({tag, " R9 phase on"}, phase, 2);
      set_en(1'b0);
      run_down(tag, 2 + EXT + ticks_cyc(dn_c, 0, sel));
   endtask

   task automatic t_cancel();
      int changes;
      configure(0, 12'h113, 12'h111, 0);
      set_en(1'b1);
      repeat (4) @(negedge clk);
      set_en(1'b0);
      @(negedge clk);
      check("R6 phase back to off", phase, 0);
      changes = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (rail != 3'b000) changes++;
      end
      check("R6 rails stay low", changes, 0);
   endtask

   task automatic t_abort();
      int n;
      configure(0, 12'h221, 12'h121, 1);
      set_en(1'b1);
      wait_rail(n);
      check("R7 rail0 before abort", rail, 3'b001);
      repeat (2) @(negedge clk);
      set_en(1'b0);
      wait_rail(n);
      check("R7 restarted rail1 delay", n, 2 + ticks_cyc(up_c, 1, sel));
      check("R7 power-up continues", rail, 3'b011);
      wait_rail(n);
      check("R7 rail2 released", rail, 3'b111);
      check("R7 rail2 delay", n, 1 + ticks_cyc(up_c, 2, sel));
      check("R7 settle phase", phase, 3);
      run_down("R7 abort", 2 + STL * CPT + EXT + ticks_cyc(dn_c, 0, sel));
   endtask

   task automatic t_reassert();
      int n;
      configure(0, 12'h111, 12'h232, 3);
      run_up("R8 pre");
      @(negedge clk);
      set_en(1'b0);
      wait_rail(n);
      check("R8 first drop delay", n, 2 + EXT + ticks_cyc(dn_c, 0, sel));
      check("R8 first drop value", rail, 3'b101);
      set_en(1'b1);
      wait_rail(n);
      check("R8 second drop ignores enable", n, ticks_cyc(dn_c, 1, sel));
      check("R8 second drop value", rail, 3'b100);
      wait_rail(n);
      check("R8 third drop delay", n, 1 + ticks_cyc(dn_c, 2, sel));
      check("R8 all low", rail, 3'b000);
      wait_rail(n);
      check("R8 fresh power-up delay", n, 2 + EXT + ticks_cyc(up_c, 0, sel));
      check("R8 fresh rail0", rail, 3'b001);
      wait_rail(n);
      wait_rail(n);
      check("R8 fresh power-up done", rail, 3'b111);
      @(negedge clk);
      set_en(1'b0);
      run_down("R8 post", 2 + EXT + ticks_cyc(dn_c, 0, sel));
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full("R2 base", 0, 12'h123, 12'h321, 0);
      t_full("R3 zero codes", 1, 12'h020, 12'h110, 4);
      t_full("R3 wide step", 3, 12'h111, 12'h101, 2);
      t_full("R5 order1", 2, 12'h101, 12'h011, 1);
      t_full("R5 order3", 0, 12'h011, 12'h110, 3);
      t_full("R5 order5", 0, 12'h110, 12'h101, 5);
      t_full("R5 order7", 0, 12'h101, 12'h011, 7);
      t_cancel();
      t_abort();
      t_reassert();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule